// File: doc/BRIEF.md
# Fractional Auxiliary Clock Output Generator

The block derives a slower auxiliary clock from the main oscillator and drives it onto a single output pin. The division ratio follows the demodulator mode. In external-demodulator mode the oscillator (nominally 76.8 kHz) is halved. In internal-demodulator mode the oscillator (nominally 160 kHz) is divided either by exactly 4 (40 kHz) or by an average of 25/6 (38.4 kHz). The 25/6 ratio comes from a phase accumulator that toggles the output when it overflows. A fractional-disable bit chooses between the two internal-mode ratios and does nothing in external mode. Before internal mode is selected, a 160 kHz oscillator therefore gives an 80 kHz output.

A static disable bit forces the pin low at once, and may cut a high phase short. An intermittent mode runs the clock only while the receiver-off indication is low, plus a guard of `GUARD_CYCLES` output periods after the indication rises. Intermittent starts and stops never produce a high or low phase shorter than the current mode's minimum half period. The receiver sequencer is expected to lower the receiver-off indication early enough to give the receiver its lead-in clocks.

The block has two resets. The power-on reset clears the divider and the output. The block reset only clears the guard counter. Outside intermittent mode, the clock keeps running while the block reset is held.

Top module: `clkout_gen`

## Requirements
- R1: With `int_demod_en`=0 the output toggles on every oscillator cycle (divide by 2), whatever the value of `frac_dis`.
- R2: With `int_demod_en`=1 and `frac_dis`=1 the output is the oscillator divided by 4, and every high and low phase lasts exactly 2 oscillator cycles.
- R3: With `int_demod_en`=1 and `frac_dis`=0 the output averages 6 periods per 25 oscillator cycles, and every phase lasts 2 or 3 oscillator cycles.
- R4: While `out_dis`=1 the output is low from the second rising oscillator edge after it is set.
- R5: With `intermit_en`=0 and `out_dis`=0, the output keeps toggling while `rst_n` is held low and `por_n` is high.
- R6: With `intermit_en`=1, the output stays low while `rx_off`=1 and the guard has expired. After `rx_off` falls, the first output rise comes within 10 oscillator cycles.
- R7: After `rx_off` rises in intermittent mode, the output gives between `GUARD_CYCLES`-1 and `GUARD_CYCLES`+1 further rising edges and then stays low.
- R8: Intermittent starts and stops never produce a phase shorter than the mode's minimum half period. The enable gate changes only while the divided clock is low.
- R9: With `intermit_en`=1, the output is held low while `rst_n` is low.
- R10: While `por_n` is low the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, clears divider and output |
| rst_n | input | 1 | Block reset, active low, clears guard counter |
| int_demod_en | input | 1 | 1 selects internal-demodulator ratios |
| frac_dis | input | 1 | 1 selects divide-by-4 instead of 25/6 in internal mode |
| out_dis | input | 1 | 1 holds the output low |
| intermit_en | input | 1 | 1 runs the output only around receiver activity |
| rx_off | input | 1 | 1 while the receiver is in its Off state |
| clk_out | output | 1 | Auxiliary clock pin |

## Verification
Two functions can act in the same cycle. In the first, the guard counter runs out while the fractional divider is mid-phase. In the second, the receiver-off indication flips while the divided clock is high. The bench provokes both by toggling `rx_off` at random intervals in the fractional and divide-by-4 modes. It records every completed high and low phase at the pin and fails if any phase is shorter than 2 oscillator cycles. Directed guard windows count the rising edges after `rx_off` rises and check that the pin then stays low.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    MODE_EXT  = 2'd0,
    MODE_INT4 = 2'd1,
    MODE_FRAC = 2'd2
  } div_mode_e;

  function automatic div_mode_e pick_mode(input logic int_en, input logic fdis);
    if (!int_en)   return MODE_EXT;
    else if (fdis) return MODE_INT4;
    else           return MODE_FRAC;
  endfunction
endpackage

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
#(
  parameter int FRAC_NUM = 6,
  parameter int FRAC_DEN = 25,
  parameter int INT_DIV  = 4,
  parameter int EXT_DIV  = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic int_demod_en,
  input  logic frac_dis,
  output logic div_q,
  output logic div_fall
);
  localparam int ACC_W = $clog2(FRAC_DEN + 1);
  localparam int SUM_W = ACC_W + 1;

  div_mode_e        mode_q, mode_d;
  logic [ACC_W-1:0] acc_q, step, modv;
  logic [SUM_W-1:0] sum;
  logic             wrap, mode_chg;

  always_comb begin
    mode_d   = pick_mode(int_demod_en, frac_dis);
    mode_chg = (mode_d != mode_q);
    case (mode_q)
      MODE_EXT:  begin step = ACC_W'(1);            modv = ACC_W'(EXT_DIV / 2); end
      MODE_INT4: begin step = ACC_W'(1);            modv = ACC_W'(INT_DIV / 2); end
      default:   begin step = ACC_W'(2 * FRAC_NUM); modv = ACC_W'(FRAC_DEN);    end
    endcase
    sum      = {1'b0, acc_q} + {1'b0, step};
    wrap     = (sum >= {1'b0, modv}) && !mode_chg;
    div_fall = wrap && div_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_EXT;
      acc_q  <= '0;
      div_q  <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= mode_d;
      acc_q  <= '0;
    end else begin
      acc_q <= wrap ? ACC_W'(sum - {1'b0, modv}) : sum[ACC_W-1:0];
      div_q <= div_q ^ wrap;
    end
  end

  // divide-by-4: a phase never lasts a single cycle
  assert_int4_phase_R2: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_INT4 && $past(mode_q) == MODE_INT4 && div_q != $past(div_q))
      |=> $stable(div_q));

  // fractional: minimum phase of two cycles
  assert_frac_phase_R3: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_FRAC && $past(mode_q) == MODE_FRAC && div_q != $past(div_q))
      |=> $stable(div_q));
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate #(
  parameter int GUARD_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic intermit_en,
  input  logic rx_off,
  input  logic div_q,
  input  logic div_fall,
  output logic gate_q
);
  localparam int CNT_W = $clog2(GUARD_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!rx_off)                cnt_q <= CNT_W'(GUARD_CYCLES);
    else if (div_fall && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  always_comb want = !intermit_en || (rst_n && (!rx_off || cnt_q != 0));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      gate_q <= 1'b0;
    else if (!div_q) gate_q <= want;
  end

  // the gate never moves while the divided clock is high
  assert_gate_low_R8: assert property (@(posedge clk) disable iff (!por_n)
    (gate_q != $past(gate_q)) |-> !$past(div_q));

  // guard expired with receiver off: gate closes at the next low phase
  assert_guard_close_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (intermit_en && rx_off && cnt_q == 0 && !div_q) |=> !gate_q);
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int FRAC_NUM     = 6,
  parameter int FRAC_DEN     = 25,
  parameter int INT_DIV      = 4,
  parameter int EXT_DIV      = 2,
  parameter int GUARD_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic int_demod_en,
  input  logic frac_dis,
  input  logic out_dis,
  input  logic intermit_en,
  input  logic rx_off,
  output logic clk_out
);
  logic div_q, div_fall, gate_q, out_q;

  clkout_div #(
    .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN), .INT_DIV(INT_DIV), .EXT_DIV(EXT_DIV)
  ) u_div (
    .clk(clk), .por_n(por_n), .int_demod_en(int_demod_en), .frac_dis(frac_dis),
    .div_q(div_q), .div_fall(div_fall)
  );

  clkout_gate #(.GUARD_CYCLES(GUARD_CYCLES)) u_gate (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .intermit_en(intermit_en),
    .rx_off(rx_off), .div_q(div_q), .div_fall(div_fall), .gate_q(gate_q)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) out_q <= 1'b0;
    else        out_q <= div_q && gate_q && !out_dis;
  end

  assign clk_out = out_q;

  assert_static_off_R4: assert property (@(posedge clk) disable iff (!por_n)
    out_dis |=> !clk_out);

  assert_rst_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
    (intermit_en && !rst_n && !div_q && $past(intermit_en) && !$past(rst_n)) |=> !gate_q);
endmodule

// File: tb/sim_clkout_gen.sv
module sim_clkout_gen;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic int_demod_en = 1'b0, frac_dis = 1'b0, out_dis = 1'b0;
  logic intermit_en = 1'b0, rx_off = 1'b0;
  logic clk_out;

  int total = 0, bad = 0;
  int rises, hi_cnt, run, min_run, max_run;
  bit prev, seen_edge;
  bit done = 0;

  always #4 clk = ~clk;

  clkout_gen #(.GUARD_CYCLES(GUARD)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .int_demod_en(int_demod_en),
    .frac_dis(frac_dis), .out_dis(out_dis), .intermit_en(intermit_en),
    .rx_off(rx_off), .clk_out(clk_out)
  );

  always @(negedge clk) begin
    if (clk_out) hi_cnt++;
    if (clk_out && !prev) rises++;
    if (clk_out == prev) run++;
    else begin
      if (seen_edge) begin
        if (run < min_run) min_run = run;
        if (run > max_run) max_run = run;
      end
      seen_edge = 1;
      run = 1;
    end
    prev = clk_out;
  end

  task automatic clear_stats();
    rises = 0; hi_cnt = 0; min_run = 999; max_run = 0; seen_edge = 0; run = 0;
  endtask

  task automatic window(input int n);
    @(posedge clk);
    clear_stats();
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rises(input int mode, input int n);
    if (mode == 0) return n / 2;
    if (mode == 1) return n / 4;
    return (n * 6) / 25;
  endfunction

  task automatic set_mode(input int mode);
    int_demod_en = (mode != 0);
    frac_dis     = (mode == 1);
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int e;
    seed = $urandom(32'd1977);
    clear_stats();
    // R10 output low during power-on reset
    idle(3);
    window(10);
    check(hi_cnt == 0, "R10 low in por", hi_cnt, 0);
    // R5 runs during block reset
    por_n = 1'b1;
    idle(4);
    window(40);
    check(iabs(rises - 20) <= 1, "R5 running in block reset", rises, 20);
    rst_n = 1'b1;
    // R1 ext mode, fractional bit ignored
    idle(4);
    window(100);
    check(iabs(rises - 50) <= 1, "R1 ext divide by 2", rises, 50);
    frac_dis = 1'b1;
    idle(4);
    window(100);
    check(iabs(rises - 50) <= 1, "R1 frac_dis ignored", rises, 50);
    // R2 divide by 4
    int_demod_en = 1'b1;
    idle(8);
    window(100);
    check(iabs(rises - 25) <= 1, "R2 divide by 4 rate", rises, 25);
    check(min_run == 2 && max_run == 2, "R2 phase length", min_run * 10 + max_run, 22);
    // R3 fractional
    frac_dis = 1'b0;
    idle(8);
    window(250);
    check(iabs(rises - 60) <= 1, "R3 fractional rate", rises, 60);
    check(min_run >= 2 && max_run <= 3, "R3 phase length", min_run * 10 + max_run, 23);
    // R4 static disable
    out_dis = 1'b1;
    idle(2);
    window(50);
    check(hi_cnt == 0, "R4 forced low", hi_cnt, 0);
    out_dis = 1'b0;
    // R6 intermittent hold
    intermit_en = 1'b1;
    rx_off = 1'b1;
    idle(60);
    window(50);
    check(hi_cnt == 0, "R6 held low while off", hi_cnt, 0);
    rx_off = 1'b0;
    window(10);
    check(rises >= 1, "R6 start latency", rises, 1);
    window(100);
    check(iabs(rises - 24) <= 1, "R6 running while on", rises, 24);
    // R7 guard
    rx_off = 1'b1;
    window(60);
    check(rises >= GUARD - 1 && rises <= GUARD + 1, "R7 guard pulses", rises, GUARD);
    window(40);
    check(hi_cnt == 0, "R7 low after guard", hi_cnt, 0);
    // R8 random gating in fractional and divide-by-4 modes
    for (int m = 2; m >= 1; m--) begin
      set_mode(m);
      rx_off = 1'b0;
      idle(10);
      @(posedge clk);
      clear_stats();
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        rx_off = ~rx_off;
        idle(1 + ($urandom % 40));
      end
      check(min_run >= 2, "R8 no short phase", min_run, 2);
    end
    // R9 intermittent held low in block reset
    set_mode(2);
    rx_off = 1'b0;
    idle(10);
    rst_n = 1'b0;
    idle(4);
    window(30);
    check(hi_cnt == 0, "R9 low in block reset", hi_cnt, 0);
    rst_n = 1'b1;
    intermit_en = 1'b0;
    // random mode selection: R1 R2 R3 rates
    for (int i = 0; i < 6; i++) begin
      int m;
      m = $urandom % 3;
      set_mode(m);
      idle(10);
      window(200);
      e = exp_rises(m, 200);
      check(iabs(rises - e) <= 1, "R1/R2/R3 random mode rate", rises, e);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule